// File: doc/BRIEF.md
# LED Status Driver with Activity Stretch

This block drives the two status LED pins of a network PHY. The board can wire each LED so that the pin either sources current to light it or sinks current to light it. While reset is held, the block samples a sensed-wiring input for each pin and keeps the last sample. After reset it drives each pin so that the chosen logical state appears correctly for that wiring.

Each LED has a 4-bit mode field. The field selects one of these behaviours: steady on, steady off, slow blink, fast blink, stretched transmit activity or stretched receive activity. Single-cycle activity pulses are widened into visible flashes of a selectable length.

The sensed wiring of the second LED also sets the reset value of a duplex-mode bit. A sinking connection selects full duplex and a sourcing connection selects half duplex. All timing comes from a millisecond tick that is divided down from the system clock.

Top module: `led_status_drv`

## Requirements
- R1: The wiring sense of both pins (`pol_sense_i`, 1 = pin sinks current to light the LED) is captured on every clock while `rst_i` is high. Changes to `pol_sense_i` after reset is released have no effect on `led_o` until the next reset.
- R2: After reset, `led_o[i]` equals the logical LED state XOR the captured sense bit i. Logical on therefore drives 1 on a sourcing pin and 0 on a sinking pin.
- R3: When reset is released, `duplex_o` equals the captured sense of the second LED: 1 (full duplex) for sinking and 0 (half duplex) for sourcing.
- R4: After reset, `duplex_o` takes `dplx_wd_i` one clock after a cycle in which `dplx_we_i` is 1. It holds its value otherwise.
- R5: Mode 0 shows logical on. Mode 1 and modes 6 to 15 show logical off.
- R6: Mode 2 blinks with a half-period of SLOW_MS ticks, 520 by default. Mode 3 blinks with a half-period of FAST_MS ticks, 130 by default. Both blink phases start at off when reset is released.
- R7: Mode 4 shows a stretched `tx_evt_i` and mode 5 shows a stretched `rx_evt_i`. A pulse loads a length of NORM_MS, MED_MS or LONG_MS ticks when `stretch_sel_i` is 0, 1 or 2/3. The loaded length counts down by one on each tick, and the LED is lit while the count is non-zero.
- R8: A pulse that arrives while a stretch is running reloads the full length.
- R9: One millisecond tick occurs every CLKS_PER_MS clocks, counted from reset release.
- R10: `led_o` is registered and follows its inputs one clock later. While `rst_i` is high, `led_o` shows logical off in the sensed wiring, so it equals the previous cycle's `pol_sense_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pol_sense_i | input | 2 | Sensed wiring per LED, 1 = sinking |
| cfg_a_i | input | 4 | Mode field of the first LED |
| cfg_b_i | input | 4 | Mode field of the second LED |
| stretch_sel_i | input | 2 | Stretch length select |
| tx_evt_i | input | 1 | Transmit activity pulse |
| rx_evt_i | input | 1 | Receive activity pulse |
| dplx_we_i | input | 1 | Duplex bit write enable |
| dplx_wd_i | input | 1 | Duplex bit write data |
| led_o | output | 2 | LED pin levels |
| duplex_o | output | 1 | Duplex-mode bit |

## Verification
On every cycle, the assertions check the following:
- the captured wiring stays frozen outside reset;
- the duplex bit matches that wiring at release and changes only on writes;
- steady modes drive the expected pin level;
- blink phases move only on ticks;
- a pulse always starts a flash.

Some behaviours can be shown only by the bench's scenarios, which compare against a behavioural model every cycle:
- the exact blink and stretch durations in clocks;
- the full-length reload on a retrigger;
- the effect of a sense change after reset.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

   typedef enum logic [3:0] {
      LM_ON        = 4'd0,
      LM_OFF       = 4'd1,
      LM_BLINK_SLO = 4'd2,
      LM_BLINK_FST = 4'd3,
      LM_TX_ACT    = 4'd4,
      LM_RX_ACT    = 4'd5
   } led_mode_e;

   typedef enum logic [1:0] {
      SL_NORMAL = 2'd0,
      SL_MEDIUM = 2'd1,
      SL_LONG   = 2'd2
   } stretch_len_e;

   localparam int unsigned NUM_LEDS = 2;
   localparam int unsigned NUM_EVTS = 2;

endpackage

// File: rtl/led_ms_tick.sv
module led_ms_tick #(
   parameter int unsigned CLKS_PER_MS = 50000
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic tick_o
);
   localparam int unsigned TW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
   localparam logic [TW-1:0] LAST = TW'(CLKS_PER_MS - 1);

   if (CLKS_PER_MS < 1) begin : g_bad_div
      $error("led_ms_tick: CLKS_PER_MS must be at least 1");
   end

   logic [TW-1:0] cnt_q;

   assign tick_o = !rst_i && (cnt_q == LAST);

   always_ff @(posedge clk_i) begin
      if (rst_i)        cnt_q <= '0;
      else if (tick_o)  cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end

   if (CLKS_PER_MS > 1) begin : g_gap_chk
      // R9
      tick_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         tick_o |=> !tick_o);
   end
endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
   parameter int unsigned HALF_MS = 520
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic tick_i,
   output logic phase_o
);
   localparam int unsigned BW = (HALF_MS > 1) ? $clog2(HALF_MS) : 1;
   localparam logic [BW-1:0] LAST = BW'(HALF_MS - 1);

   if (HALF_MS < 1) begin : g_bad_half
      $error("led_blink_gen: HALF_MS must be at least 1");
   end

   logic [BW-1:0] cnt_q;
   logic          ph_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
         ph_q  <= 1'b0;
      end else if (tick_i) begin
         if (cnt_q == LAST) begin
            cnt_q <= '0;
            ph_q  <= ~ph_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign phase_o = ph_q;

   // R6
   phase_on_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !tick_i |=> $stable(phase_o));
endmodule

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch
   import led_drv_pkg::*;
#(
   parameter int unsigned NORM_MS = 40,
   parameter int unsigned MED_MS  = 70,
   parameter int unsigned LONG_MS = 140
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       tick_i,
   input  logic       evt_i,
   input  logic [1:0] sel_i,
   output logic       active_o
);
   localparam int unsigned SW = $clog2(LONG_MS + 1);

   logic [SW-1:0] len;
   logic [SW-1:0] cnt_q;

   always_comb begin
      case (sel_i)
         SL_NORMAL: len = SW'(NORM_MS);
         SL_MEDIUM: len = SW'(MED_MS);
         default:   len = SW'(LONG_MS);
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)                        cnt_q <= '0;
      else if (evt_i)                   cnt_q <= len;
      else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign active_o = (cnt_q != '0);

   // R7
   evt_lights_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      evt_i |=> active_o);
   // R8
   evt_full_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      evt_i |=> (cnt_q == $past(len)));
   // R7
   hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!evt_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
   import led_drv_pkg::*;
#(
   parameter int unsigned CLKS_PER_MS = 50000,
   parameter int unsigned SLOW_MS     = 520,
   parameter int unsigned FAST_MS     = 130,
   parameter int unsigned NORM_MS     = 40,
   parameter int unsigned MED_MS      = 70,
   parameter int unsigned LONG_MS     = 140
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic [1:0] pol_sense_i,
   input  logic [3:0] cfg_a_i,
   input  logic [3:0] cfg_b_i,
   input  logic [1:0] stretch_sel_i,
   input  logic       tx_evt_i,
   input  logic       rx_evt_i,
   input  logic       dplx_we_i,
   input  logic       dplx_wd_i,
   output logic [1:0] led_o,
   output logic       duplex_o
);
   if (NORM_MS < 1 || MED_MS < NORM_MS || LONG_MS < MED_MS) begin : g_bad_len
      $error("led_status_drv: stretch lengths must be ordered and non-zero");
   end
   if (FAST_MS > SLOW_MS) begin : g_bad_blink
      $error("led_status_drv: fast blink must not be slower than slow blink");
   end

   logic                tick;
   logic                slow_ph, fast_ph;
   logic [NUM_EVTS-1:0] evt_vec;
   logic [NUM_EVTS-1:0] act_vec;
   logic [NUM_LEDS-1:0] pol_q;
   logic [NUM_LEDS-1:0] lit;
   logic [NUM_LEDS-1:0] led_q;
   logic                dplx_q;
   logic [3:0]          cfg_arr [NUM_LEDS];

   assign cfg_arr[0] = cfg_a_i;
   assign cfg_arr[1] = cfg_b_i;
   assign evt_vec    = {rx_evt_i, tx_evt_i};

   led_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .tick_o(tick)
   );

   led_blink_gen #(.HALF_MS(SLOW_MS)) u_blink_slow (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .tick_i (tick),
      .phase_o(slow_ph)
   );

   led_blink_gen #(.HALF_MS(FAST_MS)) u_blink_fast (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .tick_i (tick),
      .phase_o(fast_ph)
   );

   for (genvar e = 0; e < NUM_EVTS; e++) begin : g_stretch
      led_pulse_stretch #(
         .NORM_MS(NORM_MS),
         .MED_MS (MED_MS),
         .LONG_MS(LONG_MS)
      ) u_str (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .tick_i  (tick),
         .evt_i   (evt_vec[e]),
         .sel_i   (stretch_sel_i),
         .active_o(act_vec[e])
      );
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) pol_q <= pol_sense_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)          dplx_q <= pol_sense_i[1];
      else if (dplx_we_i) dplx_q <= dplx_wd_i;
   end

   for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
      always_comb begin
         case (cfg_arr[i])
            LM_ON:        lit[i] = 1'b1;
            LM_OFF:       lit[i] = 1'b0;
            LM_BLINK_SLO: lit[i] = slow_ph;
            LM_BLINK_FST: lit[i] = fast_ph;
            LM_TX_ACT:    lit[i] = act_vec[0];
            LM_RX_ACT:    lit[i] = act_vec[1];
            default:      lit[i] = 1'b0;
         endcase
      end

      always_ff @(posedge clk_i) begin
         if (rst_i) led_q[i] <= pol_sense_i[i];
         else       led_q[i] <= lit[i] ^ pol_q[i];
      end

      // R5
      steady_on_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         (cfg_arr[i] == 4'd0) |=> (led_o[i] != pol_q[i]));
      // R5
      steady_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         (cfg_arr[i] == 4'd1 || cfg_arr[i] > 4'd5) |=> (led_o[i] == pol_q[i]));
   end

   assign led_o    = led_q;
   assign duplex_o = dplx_q;

   // R1
   pol_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_i |=> $stable(pol_q));
   // R3
   dplx_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(rst_i) |-> (duplex_o == pol_q[1]));
   // R4
   dplx_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !dplx_we_i |=> $stable(duplex_o));
endmodule

// File: tb/led_status_drv_tb.sv
module led_status_drv_tb;
   localparam int CPM  = 4;
   localparam int SLOW = 520;
   localparam int FAST = 130;
   localparam int LN   = 40;
   localparam int LM   = 70;
   localparam int LL   = 140;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] pol_sense = 2'b10;
   logic [3:0] cfg_a = 4'd1, cfg_b = 4'd1;
   logic [1:0] sel = 2'd0;
   logic       tx_evt = 1'b0, rx_evt = 1'b0;
   logic       dwe = 1'b0, dwd = 1'b0;
   logic [1:0] led_o;
   logic       duplex_o;

   int checks = 0, failures = 0, cyc = 0;
   bit done = 0;

   always #10 clk = ~clk;

   led_status_drv #(.CLKS_PER_MS(CPM)) u_dut (
      .clk_i(clk), .rst_i(rst), .pol_sense_i(pol_sense),
      .cfg_a_i(cfg_a), .cfg_b_i(cfg_b), .stretch_sel_i(sel),
      .tx_evt_i(tx_evt), .rx_evt_i(rx_evt),
      .dplx_we_i(dwe), .dplx_wd_i(dwd),
      .led_o(led_o), .duplex_o(duplex_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
      end
   endtask

   // behavioural reference model
   bit m_ok = 0;
   int m_pol[2], m_led[2], m_str[2];
   int m_dplx, m_tc, m_sc, m_sp, m_fc, m_fp;

   function automatic int len_of(input int s);
      if (s == 0) return LN;
      if (s == 1) return LM;
      return LL;
   endfunction

   function automatic int logic_of(input int c);
      case (c)
         0: return 1;
         2: return m_sp;
         3: return m_fp;
         4: return (m_str[0] > 0) ? 1 : 0;
         5: return (m_str[1] > 0) ? 1 : 0;
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(input int c);
      if (c == 2 || c == 3) return "R6";
      if (c == 4 || c == 5) return "R7";
      return "R5";
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         for (int i = 0; i < 2; i++) begin
            m_pol[i] = pol_sense[i];
            m_led[i] = pol_sense[i];
            m_str[i] = 0;
         end
         m_dplx = pol_sense[1];
         m_tc = 0; m_sc = 0; m_sp = 0; m_fc = 0; m_fp = 0;
      end else begin
         bit tk;
         int ev[2];
         tk = (m_tc == CPM - 1);
         m_led[0] = logic_of(cfg_a) ^ m_pol[0];
         m_led[1] = logic_of(cfg_b) ^ m_pol[1];
         if (dwe) m_dplx = dwd;
         m_tc = tk ? 0 : m_tc + 1;
         if (tk) begin
            if (m_sc == SLOW - 1) begin m_sc = 0; m_sp ^= 1; end else m_sc++;
            if (m_fc == FAST - 1) begin m_fc = 0; m_fp ^= 1; end else m_fc++;
         end
         ev[0] = tx_evt; ev[1] = rx_evt;
         for (int e = 0; e < 2; e++) begin
            if (ev[e] != 0) m_str[e] = len_of(sel);
            else if (tk && m_str[e] > 0) m_str[e]--;
         end
      end
      m_ok = 1;
   end

   always @(negedge clk) begin
      if (m_ok && !done) begin
         chk(rst ? "R10" : tag_of(cfg_a), led_o[0], m_led[0]);
         chk(rst ? "R10" : tag_of(cfg_b), led_o[1], m_led[1]);
         chk(rst ? "R3" : "R4", duplex_o, m_dplx);
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired: actual=%0d expected<=%0d", cyc, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_tx();
      tx_evt = 1'b1; @(negedge clk); tx_evt = 1'b0;
   endtask

   initial begin
      int t0, t1;
      logic prev;
      wait_cyc(4);
      // R10: in reset the pins show logical off in the sensed wiring
      chk("R10", led_o, 2'b10);
      @(negedge clk); rst = 1'b0;
      @(negedge clk);
      // R3: second LED sinks -> full duplex
      chk("R3", duplex_o, 1);

      // R1: sense change after reset ignored
      pol_sense = 2'b01;
      wait_cyc(6);
      chk("R1", led_o, 2'b10);

      // R2: logical on inverted for the sinking pin
      cfg_a = 4'd0; cfg_b = 4'd0;
      wait_cyc(2);
      chk("R2", led_o, 2'b01);

      // R5: reserved codes stay off
      cfg_a = 4'd7; cfg_b = 4'd15;
      wait_cyc(3);
      chk("R5", led_o, 2'b10);

      // R6/R9: fast blink half-period in clocks
      cfg_a = 4'd3; cfg_b = 4'd2;
      prev = led_o[0];
      while (led_o[0] == prev) @(negedge clk);
      t0 = cyc; prev = led_o[0];
      while (led_o[0] == prev) @(negedge clk);
      t1 = cyc;
      chk("R9", t1 - t0, FAST * CPM);
      wait_cyc(2 * SLOW * CPM);

      // R8: retrigger reloads the full length
      cfg_a = 4'd4; cfg_b = 4'd5; sel = 2'd0;
      wait_cyc(LL * CPM + 8);
      pulse_tx();
      wait_cyc(30 * CPM);
      pulse_tx();
      wait_cyc(35 * CPM);
      chk("R8", led_o[0], 1);
      wait_cyc(10 * CPM);
      chk("R8", led_o[0], 0);

      // R7: medium and long lengths, both events together
      sel = 2'd1;
      tx_evt = 1'b1; rx_evt = 1'b1; @(negedge clk); tx_evt = 1'b0; rx_evt = 1'b0;
      wait_cyc(LM * CPM + 8);
      chk("R7", led_o, 2'b10);
      sel = 2'd3;
      rx_evt = 1'b1; @(negedge clk); rx_evt = 1'b0;
      wait_cyc(LM * CPM + 8);
      chk("R7", led_o[1], 0);
      wait_cyc((LL - LM) * CPM + 8);
      chk("R7", led_o[1], 1);
      sel = 2'd2;
      for (int k = 0; k < 20; k++) begin
         if (k % 3 == 0) pulse_tx(); else wait_cyc(7 * CPM);
      end
      wait_cyc(LL * CPM + 8);

      // R4: software write and hold
      dwe = 1'b1; dwd = 1'b0; @(negedge clk); dwe = 1'b0; dwd = 1'b1;
      chk("R4", duplex_o, 0);
      wait_cyc(5);
      chk("R4", duplex_o, 0);

      // R3: second reset with second LED sourcing
      rst = 1'b1; pol_sense = 2'b01;
      wait_cyc(3);
      chk("R10", led_o, 2'b01);
      rst = 1'b0;
      @(negedge clk);
      chk("R3", duplex_o, 0);
      cfg_a = 4'd0; cfg_b = 4'd1;
      wait_cyc(2);
      chk("R2", led_o, 2'b00);
      wait_cyc(20);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule